// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Preamble and Break

This block turns host-written bytes into an asynchronous serial bit stream. A one-entry holding register takes each write. When the line is free, the contents move into a shift register. A frame is then sent as a start bit, 8 or 9 data bits with the least significant bit first, and a stop bit. The line rests at 1 whenever nothing is being sent.

Turning the enable on makes the block first send one whole group of ones, the idle preamble, before any data. Holding the break request sends back-to-back groups of zeros until the request drops. After a break, the line always goes back to 1 for at least one bit time.

An external single-cycle bit-rate tick paces the block, and the block changes state only on that tick. Two status flags, holding-register-empty and transmission-complete, are combined with their own enable inputs to form one interrupt request.

Top module: `serial_tx`

## Requirements
- R1: After reset the line is 1, the holding-register-empty flag is 1 and the transmission-complete flag is 1.
- R2: With the 9-bit select low, a frame is 10 bit times long: a 0, then write-data bits 0 to 7 in that order, then a 1.
- R3: With the 9-bit select high, a frame is 11 bit times long: a 0, then write-data bits 0 to 8 in that order, then a 1.
- R4: A 0-to-1 change of the enable queues an idle preamble of ones. It is 10 bit times long with the 9-bit select low and 11 bit times long with it high, and it goes out before any data frame.
- R5: While the break request and the enable are both high, the line carries back-to-back groups of zeros. Each group is 10 or 11 bit times long, following the 9-bit select in the same way as R4.
- R6: When the break request drops, the current break group finishes. The line is then 1 for at least one bit time before any later group starts.
- R7: A write strobe clears the holding-register-empty flag at the next clock. The flag sets again at the tick on which that data moves into the shift register.
- R8: Transmission-complete is 1 only when no group is on the line, the holding register is empty and no preamble is waiting.
- R9: The interrupt request is 1 when holding-register-empty is 1 and its enable is 1, or when transmission-complete is 1 and its enable is 1.
- R10: The line changes only at a clock edge where the bit-rate tick is high.
- R11: While the enable is low, no new group starts. Written data waits in the holding register.
- R12: When the holding register is full at the last tick of a frame or preamble, the next frame follows with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit time |
| txEnable | input | 1 | Transmitter enable |
| breakReq | input | 1 | Send break groups while high |
| nineBit | input | 1 | 1 selects 9-bit data frames |
| wrStrobe | input | 1 | Holding register write strobe |
| wrData | input | 9 | Write data; bit 8 is used only in 9-bit frames |
| ieEmpty | input | 1 | Interrupt enable for holding-register-empty |
| ieDone | input | 1 | Interrupt enable for transmission-complete |
| txLine | output | 1 | Serial output line |
| holdEmpty | output | 1 | Holding register empty flag |
| txDone | output | 1 | Transmission complete flag |
| irq | output | 1 | Gated interrupt request |

## Verification
A bit counter that is off by one, or a latched frame length that is wrong, shows on the line in the same tick: a frame, preamble or break group comes out one bit too long or too short. A wrong holding-register flag shows within one clock on holdEmpty and irq. It can also show as a frame that carries stale data or is dropped, seen one bit time later. The reference model predicts the line and all three flags for every clock, so any wrong state is reported at the first clock where it changes a port.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_BRK  = 2'd3
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // move holding register into shift register
    logic shift;  // advance shift register by one bit
    logic nine;   // frame length for the load
  } dpCmd_t;
endpackage

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitTick,
  input  logic   txEnable,
  input  logic   breakReq,
  input  logic   nineBit,
  input  logic   holdEmpty,
  input  logic   shiftBit,
  output dpCmd_t cmd,
  output logic   txLine,
  output logic   idleNow
);
  localparam int GRP_MAX = DATA_W + 3;
  localparam int CNT_W = $clog2(GRP_MAX);
  localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(GRP_MAX - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(GRP_MAX - 2);

  txState_e state, nxt;
  logic [CNT_W-1:0] cnt;
  logic nineLat, enPrev, preReq;
  logic grpLast, atBoundary, startPre;

  assign grpLast = (state != ST_IDLE) && (cnt == (nineLat ? LAST_LONG : LAST_SHORT));
  assign atBoundary = (state == ST_IDLE) || grpLast;

  always_comb begin
    nxt = state;
    cmd = '0;
    cmd.nine = nineBit;
    startPre = 1'b0;
    if (bitTick) begin
      if (state == ST_BRK && grpLast) begin
        nxt = (txEnable && breakReq) ? ST_BRK : ST_IDLE;
      end else if (atBoundary) begin
        if (!txEnable) nxt = ST_IDLE;
        else if (breakReq) nxt = ST_BRK;
        else if (preReq) begin
          nxt = ST_PRE;
          startPre = 1'b1;
        end else if (!holdEmpty) begin
          nxt = ST_DATA;
          cmd.load = 1'b1;
        end else nxt = ST_IDLE;
      end
      if (state == ST_DATA && !grpLast) cmd.shift = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      nineLat <= 1'b0;
    end else if (bitTick) begin
      state <= nxt;
      cnt   <= atBoundary ? '0 : cnt + 1'b1;
      if (atBoundary) nineLat <= nineBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      preReq <= 1'b0;
    end else begin
      enPrev <= txEnable;
      if (!txEnable) preReq <= 1'b0;
      else if (!enPrev) preReq <= 1'b1;
      else if (startPre) preReq <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      ST_BRK:  txLine = 1'b0;
      ST_DATA: txLine = shiftBit;
      default: txLine = 1'b1;
    endcase
  end

  assign idleNow = (state == ST_IDLE) && !preReq;
endmodule

// File: rtl/serial_tx_dp.sv
module serial_tx_dp
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              wrStrobe,
  input  logic [DATA_W:0]   wrData,
  output logic              holdEmpty,
  output logic              shiftBit
);
  localparam int GRP_MAX = DATA_W + 3;

  logic [DATA_W:0]    holdReg;
  logic [GRP_MAX-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdEmpty <= 1'b1;
    end else begin
      if (cmd.load) holdEmpty <= 1'b1;
      if (wrStrobe) begin
        holdReg   <= wrData;
        holdEmpty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '1;
    else if (cmd.load)
      shReg <= cmd.nine ? {1'b1, holdReg, 1'b0}
                        : {2'b11, holdReg[DATA_W-1:0], 1'b0};
    else if (cmd.shift) shReg <= {1'b1, shReg[GRP_MAX-1:1]};
  end

  assign shiftBit = shReg[0];
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bitTick,
  input  logic            txEnable,
  input  logic            breakReq,
  input  logic            nineBit,
  input  logic            wrStrobe,
  input  logic [DATA_W:0] wrData,
  input  logic            ieEmpty,
  input  logic            ieDone,
  output logic            txLine,
  output logic            holdEmpty,
  output logic            txDone,
  output logic            irq
);
  dpCmd_t cmd;
  logic shiftBit, idleNow;

  serial_tx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .breakReq(breakReq), .nineBit(nineBit), .holdEmpty(holdEmpty),
    .shiftBit(shiftBit), .cmd(cmd), .txLine(txLine), .idleNow(idleNow)
  );

  serial_tx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrStrobe(wrStrobe),
    .wrData(wrData), .holdEmpty(holdEmpty), .shiftBit(shiftBit)
  );

  assign txDone = idleNow && holdEmpty;
  assign irq = (holdEmpty && ieEmpty) || (txDone && ieDone);
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic wrStrobe,
  input logic ieEmpty,
  input logic ieDone,
  input logic txLine,
  input logic holdEmpty,
  input logic txDone,
  input logic irq
);
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txLine)); // R10
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !holdEmpty); // R7
  AST_EMPTY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> $past(bitTick)); // R7
  AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> holdEmpty); // R8
  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txLine); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ieEmpty || ieDone)); // R9
endmodule

bind serial_tx serial_tx_chk chk_i (.*);

// File: tb/tb_serial_tx.sv
module tb_serial_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic txEnable = 1'b0, breakReq = 1'b0, nineBit = 1'b0;
  logic wrStrobe = 1'b0;
  logic [8:0] wrData = '0;
  logic ieEmpty = 1'b0, ieDone = 1'b0;
  logic txLine, holdEmpty, txDone, irq;

  int total = 0, bad = 0, cycles = 0, tickCnt = 0;
  string curReq = "R1";

  always #10 clk = ~clk; // 50 MHz

  serial_tx dut (.*);

  // tick every fourth clock, driven away from the active edge
  always @(negedge clk) begin
    tickCnt++;
    bitTick <= (tickCnt % 4 == 3);
  end

  // behavioural reference model
  bit q[$];
  bit mHE = 1, mPre = 0, mEnPrev = 0, mLastBrk = 0;
  logic [8:0] mHold = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mHE = 1; mPre = 0; mEnPrev = 0; mLastBrk = 0;
    end else begin
      bit ld;
      int len;
      ld = 0;
      if (bitTick) begin
        if (q.size() > 0) void'(q.pop_front());
        if (q.size() == 0) begin
          if (mLastBrk && !(txEnable && breakReq)) mLastBrk = 0;
          else begin
            mLastBrk = 0;
            len = nineBit ? 11 : 10;
            if (!txEnable) ;
            else if (breakReq) begin
              for (int i = 0; i < len; i++) q.push_back(1'b0);
              mLastBrk = 1;
            end else if (mPre) begin
              for (int i = 0; i < len; i++) q.push_back(1'b1);
              mPre = 0;
            end else if (!mHE) begin
              q.push_back(1'b0);
              for (int i = 0; i < len - 2; i++) q.push_back(mHold[i]);
              q.push_back(1'b1);
              ld = 1;
            end
          end
        end
      end
      if (ld) mHE = 1;
      if (wrStrobe) begin mHE = 0; mHold = wrData; end
      if (!txEnable) mPre = 0;
      else if (!mEnPrev) mPre = 1;
      mEnPrev = txEnable;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, mid-cycle
  always @(negedge clk) if (rstN) begin
    bit eLine, eDone;
    eLine = (q.size() > 0) ? q[0] : 1'b1;
    eDone = (q.size() == 0) && mHE && !mPre;
    chk(curReq, "line", txLine, eLine);
    chk("R7", "holdEmpty", holdEmpty, mHE);
    chk("R8", "txDone", txDone, eDone);
    chk("R9", "irq", irq, (mHE && ieEmpty) || (eDone && ieDone));
  end

  task automatic waitTicks(int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic wr(logic [8:0] d);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = d;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitEmpty();
    int n = 0;
    while (!holdEmpty && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic waitDone();
    int n = 0;
    while (!txDone && n < 400) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset line", txLine, 1);
    chk("R1", "reset holdEmpty", holdEmpty, 1);
    chk("R1", "reset txDone", txDone, 1);

    // preamble then back-to-back 8-bit frames
    curReq = "R4"; ieEmpty = 1'b1;
    txEnable = 1'b1;
    @(negedge clk);
    chk("R8", "done low with preamble waiting", txDone, 0);
    wr(9'h0A5);
    waitEmpty();
    curReq = "R12";
    wr(9'h03C);
    curReq = "R2";
    waitDone();
    chk("R2", "done after frames", txDone, 1);

    // 9-bit frame
    curReq = "R3"; nineBit = 1'b1; ieDone = 1'b1; ieEmpty = 1'b0;
    wr(9'h1C3);
    waitEmpty();
    wr(9'h0F0);
    waitDone();

    // break, with data waiting, then release
    curReq = "R5"; breakReq = 1'b1;
    wr(9'h155);
    waitTicks(26);
    nineBit = 1'b0;
    waitTicks(14);
    curReq = "R6"; breakReq = 1'b0;
    waitDone();

    // disabled: data must wait
    curReq = "R11"; txEnable = 1'b0;
    waitTicks(2);
    wr(9'h081);
    waitTicks(30);
    chk("R11", "held while disabled", holdEmpty, 0);
    chk("R11", "line idle while disabled", txLine, 1);

    // re-enable: preamble (9-bit) then the waiting byte
    curReq = "R4"; nineBit = 1'b1; ieEmpty = 1'b1; ieDone = 1'b0;
    txEnable = 1'b1;
    waitEmpty();
    curReq = "R10";
    waitDone();
    waitTicks(3);
    chk("R9", "irq from empty", irq, 1);
    ieEmpty = 1'b0;
    @(negedge clk);
    chk("R9", "irq masked", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule